// File: doc/BRIEF.md
# Local Bus Arbiter with Host Pre-emption

This block shares one local bus between two masters. The first is a communications processor that moves data in DMA bursts. The second is a host-side bridge that issues single programmed-I/O accesses. The processor is granted the bus whenever it asks and no host access is waiting for the bus. A host access that arrives while the processor owns the bus forces the processor off the bus. The block then runs the host cycle itself and hands the bus back afterwards, but only if the processor reports that its DMA sequence is still running.

The local bus is big-endian. The even byte offset maps to bits 15:8 and the odd offset maps to bits 7:0. The host may use 16-bit or 8-bit accesses. Byte accesses to a configurable set of staged words follow an odd-then-even order:
- An odd-byte write is held in a staging byte, and the following even-byte write issues one merged 16-bit write.
- An odd-byte read fetches the whole word, returns the low byte and keeps the high byte for the following even-byte read.

One word address is reserved for the block's own configuration register. Host accesses to that word never appear on the local bus.

Top module: `lbus_arbiter`

## Requirements
- R1: After reset, procGrant, procRelinquish, lbStrobe, hostDone and releaseTimeout are low. With the arbiter idle and no host bus access pending, a high procReq at a clock edge raises procGrant from the next cycle. procGrant stays high until procReq is sampled low.
- R2: When a host bus access is pending while procGrant is high, procGrant drops and procRelinquish rises in the next cycle. procRelinquish holds while procBusAck is high. lbStrobe is issued in the cycle after procBusAck is sampled low.
- R3: After a pre-empted host cycle, the arbiter samples procDmaActive in the cycle after lbStrobe. If it is high, procGrant returns one cycle later; if it is low, the arbiter goes idle without granting.
- R4: Host accesses to word CFG_WORD (offsets 0xE/0xF by default) never produce lbStrobe. Reads return the configuration register, which resets to CFG_RESET. Writes update it per byte lane.
- R5: Byte lanes are big-endian. An even offset uses lbWdata/lbRdata bits 15:8 with lbByteEn = 2'b10, and an odd offset uses bits 7:0 with lbByteEn = 2'b01. Host byte data travels on hostWdata/hostRdata bits 7:0, and the upper host bits read as zero.
- R6: For a staged word (STAGED_MASK bit set; words 0 to 2 by default), an odd-byte write completes without lbStrobe and is held. The next even-byte write to a staged word issues one 16-bit write {even byte, held odd byte} with lbByteEn = 2'b11.
- R7: For a staged word, an odd-byte read issues a 16-bit read with lbByteEn = 2'b11 and returns bits 7:0. Bits 15:8 are held, and a later even-byte read to a staged word returns the held byte without lbStrobe.
- R8: 16-bit host accesses to any word other than CFG_WORD pass to the local bus with lbByteEn = 2'b11. The data is unchanged, and a read returns lbRdata.
- R9: If procBusAck stays high for RELEASE_LIMIT cycles while procRelinquish is asserted, releaseTimeout is set. It stays set until reset, and the arbiter keeps waiting for the release.
- R10: When a host bus access is pending and procReq is high in the idle state, the host cycle runs first and procGrant follows afterwards.
- R11: hostDone is a one-cycle pulse. Counted from the cycle in which hostReq is high, it comes two cycles later for an access that needs no bus, and three cycles later for a bus access started from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| procReq | input | 1 | Processor bus request |
| procBusAck | input | 1 | Processor is driving the bus; low means released |
| procDmaActive | input | 1 | Processor DMA sequence not yet finished |
| procGrant | output | 1 | Bus granted to processor |
| procRelinquish | output | 1 | Request for the processor to release the bus |
| hostReq | input | 1 | One-cycle host access request |
| hostWrite | input | 1 | Host access is a write |
| hostByte | input | 1 | Host access is 8-bit (else 16-bit) |
| hostAddr | input | ADDR_W | Host I/O byte offset |
| hostWdata | input | 16 | Host write data (byte on bits 7:0) |
| hostRdata | output | 16 | Host read data, held until the next read |
| hostDone | output | 1 | One-cycle completion pulse |
| lbStrobe | output | 1 | Local bus cycle strobe |
| lbWrite | output | 1 | Local bus cycle is a write |
| lbAddr | output | ADDR_W | Local bus byte address (word aligned) |
| lbByteEn | output | 2 | Lane enables: bit 1 = bits 15:8, bit 0 = bits 7:0 |
| lbWdata | output | 16 | Local bus write data |
| lbRdata | input | 16 | Local bus read data, sampled at the end of the strobe cycle |
| releaseTimeout | output | 1 | Sticky release timeout flag |

## Verification
The bench builds the block with RELEASE_LIMIT = 4. This lets a processor that refuses to release reach the timeout flag within a handful of cycles, while a second, well-behaved processor with a two-cycle release delay exercises the normal wait. CFG_RESET is set to 16'hA5C3 so that the reset value of the configuration register is distinct from zero-filled bus data. STAGED_MASK and CFG_WORD keep their defaults, so staged and unstaged byte lanes, pass-through words and the reserved word can all be reached through a three-bit word index.

// File: rtl/lbus_arb_pkg.sv
package lbus_arb_pkg;

  localparam int LANE_W = 8;
  localparam int DATA_W = 2 * LANE_W;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PROC_OWNS,
    S_WAIT_RELEASE,
    S_HOST_CYCLE,
    S_REGRANT_CHECK
  } arbState_t;

  // control -> datapath
  typedef struct packed {
    logic doLocal;  // complete the pending access without the bus
    logic doBus;    // run the pending access on the local bus now
  } arbStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic pendValid;
    logic needsBus;
  } dpStatus_t;

endpackage

// File: rtl/lbus_arb_ctrl.sv
module lbus_arb_ctrl
  import lbus_arb_pkg::*;
#(
  parameter int RELEASE_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       procReq,
  input  logic       procBusAck,
  input  logic       procDmaActive,
  input  dpStatus_t  dpStat,
  output arbStrobe_t strobe,
  output logic       procGrant,
  output logic       procRelinquish,
  output logic       releaseTimeout
);

  localparam int CNT_W = $clog2(RELEASE_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RELEASE_LIMIT - 1);

  arbState_t       state, nextState;
  logic            preempted;
  logic [CNT_W-1:0] waitCnt;
  logic            hostWantsBus;

  assign hostWantsBus = dpStat.pendValid & dpStat.needsBus;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (hostWantsBus)      nextState = S_HOST_CYCLE;
        else if (procReq)      nextState = S_PROC_OWNS;
      end
      S_PROC_OWNS: begin
        if (hostWantsBus)      nextState = S_WAIT_RELEASE;
        else if (!procReq)     nextState = S_IDLE;
      end
      S_WAIT_RELEASE: begin
        if (!procBusAck)       nextState = S_HOST_CYCLE;
      end
      S_HOST_CYCLE: begin
        nextState = preempted ? S_REGRANT_CHECK : S_IDLE;
      end
      S_REGRANT_CHECK: begin
        nextState = procDmaActive ? S_PROC_OWNS : S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state          <= S_IDLE;
      preempted      <= 1'b0;
      waitCnt        <= '0;
      releaseTimeout <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_PROC_OWNS && hostWantsBus)
        preempted <= 1'b1;
      else if (state == S_REGRANT_CHECK)
        preempted <= 1'b0;
      if (state == S_WAIT_RELEASE && procBusAck) begin
        if (waitCnt == CNT_LAST) releaseTimeout <= 1'b1;
        else                     waitCnt <= waitCnt + 1'b1;
      end else begin
        waitCnt <= '0;
      end
    end
  end

  assign strobe.doLocal  = dpStat.pendValid & ~dpStat.needsBus;
  assign strobe.doBus    = (state == S_HOST_CYCLE);
  assign procGrant       = (state == S_PROC_OWNS);
  assign procRelinquish  = (state == S_WAIT_RELEASE);

endmodule

// File: rtl/lbus_host_dp.sv
module lbus_host_dp
  import lbus_arb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [(1<<(ADDR_W-1))-1:0] STAGED_MASK = 'b111,
  parameter int unsigned CFG_WORD = 7,
  parameter logic [DATA_W-1:0] CFG_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostByte,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostDone,
  input  arbStrobe_t        strobe,
  output dpStatus_t         dpStat,
  output logic              lbStrobe,
  output logic              lbWrite,
  output logic [ADDR_W-1:0] lbAddr,
  output logic [1:0]        lbByteEn,
  output logic [DATA_W-1:0] lbWdata,
  input  logic [DATA_W-1:0] lbRdata
);

  localparam int WIDX_W = ADDR_W - 1;
  localparam logic [WIDX_W-1:0] CFG_IDX = WIDX_W'(CFG_WORD);
  localparam logic [LANE_W-1:0] ZERO_LANE = '0;

  logic              pendValid, pendWrite, pendByte, pendOdd;
  logic [WIDX_W-1:0] pendWord;
  logic [DATA_W-1:0] pendWdata;
  logic [LANE_W-1:0] wrStage, rdStage;
  logic [DATA_W-1:0] cfgReg;

  logic isCfg, isStaged, stageOddWr, stageEvenRd;
  logic [DATA_W-1:0] cfgRead, busReturn;

  assign isCfg       = (pendWord == CFG_IDX);
  assign isStaged    = STAGED_MASK[pendWord] & ~isCfg;
  assign stageOddWr  = isStaged & pendByte &  pendWrite &  pendOdd;
  assign stageEvenRd = isStaged & pendByte & ~pendWrite & ~pendOdd;

  assign dpStat.pendValid = pendValid;
  assign dpStat.needsBus  = ~(isCfg | stageOddWr | stageEvenRd);

  // lane selection for host byte returns (big-endian: even offset is high lane)
  always_comb begin
    if (!pendByte)    cfgRead = cfgReg;
    else if (pendOdd) cfgRead = {ZERO_LANE, cfgReg[LANE_W-1:0]};
    else              cfgRead = {ZERO_LANE, cfgReg[DATA_W-1:LANE_W]};
    if (!pendByte)    busReturn = lbRdata;
    else if (pendOdd) busReturn = {ZERO_LANE, lbRdata[LANE_W-1:0]};
    else              busReturn = {ZERO_LANE, lbRdata[DATA_W-1:LANE_W]};
  end

  always_comb begin
    if (!pendByte)     lbWdata = pendWdata;
    else if (isStaged) lbWdata = {pendWdata[LANE_W-1:0], wrStage};
    else if (pendOdd)  lbWdata = {ZERO_LANE, pendWdata[LANE_W-1:0]};
    else               lbWdata = {pendWdata[LANE_W-1:0], ZERO_LANE};
    if (!pendByte || isStaged) lbByteEn = 2'b11;
    else if (pendOdd)          lbByteEn = 2'b01;
    else                       lbByteEn = 2'b10;
  end

  assign lbStrobe = strobe.doBus;
  assign lbWrite  = strobe.doBus & pendWrite;
  assign lbAddr   = {pendWord, 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendWrite <= 1'b0;
      pendByte  <= 1'b0;
      pendOdd   <= 1'b0;
      pendWord  <= '0;
      pendWdata <= '0;
      wrStage   <= '0;
      rdStage   <= '0;
      cfgReg    <= CFG_RESET;
      hostRdata <= '0;
      hostDone  <= 1'b0;
    end else begin
      hostDone <= strobe.doLocal | strobe.doBus;
      if (hostReq && !pendValid) begin
        pendValid <= 1'b1;
        pendWrite <= hostWrite;
        pendByte  <= hostByte;
        pendOdd   <= hostAddr[0];
        pendWord  <= hostAddr[ADDR_W-1:1];
        pendWdata <= hostWdata;
      end else if (strobe.doLocal || strobe.doBus) begin
        pendValid <= 1'b0;
      end

      if (strobe.doLocal) begin
        if (isCfg) begin
          if (!pendWrite)    hostRdata <= cfgRead;
          else if (!pendByte) cfgReg <= pendWdata;
          else if (pendOdd)  cfgReg[LANE_W-1:0] <= pendWdata[LANE_W-1:0];
          else               cfgReg[DATA_W-1:LANE_W] <= pendWdata[LANE_W-1:0];
        end else if (pendWrite) begin
          wrStage <= pendWdata[LANE_W-1:0];
        end else begin
          hostRdata <= {ZERO_LANE, rdStage};
        end
      end

      if (strobe.doBus && !pendWrite) begin
        hostRdata <= busReturn;
        if (isStaged && pendByte && pendOdd)
          rdStage <= lbRdata[DATA_W-1:LANE_W];
      end
    end
  end

endmodule

// File: rtl/lbus_arbiter.sv
module lbus_arbiter
  import lbus_arb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [(1<<(ADDR_W-1))-1:0] STAGED_MASK = 'b111,
  parameter int unsigned CFG_WORD = 7,
  parameter logic [DATA_W-1:0] CFG_RESET = '0,
  parameter int RELEASE_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procReq,
  input  logic              procBusAck,
  input  logic              procDmaActive,
  output logic              procGrant,
  output logic              procRelinquish,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostByte,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostDone,
  output logic              lbStrobe,
  output logic              lbWrite,
  output logic [ADDR_W-1:0] lbAddr,
  output logic [1:0]        lbByteEn,
  output logic [DATA_W-1:0] lbWdata,
  input  logic [DATA_W-1:0] lbRdata,
  output logic              releaseTimeout
);

  arbStrobe_t strobe;
  dpStatus_t  dpStat;

  lbus_arb_ctrl #(
    .RELEASE_LIMIT(RELEASE_LIMIT)
  ) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .procReq        (procReq),
    .procBusAck     (procBusAck),
    .procDmaActive  (procDmaActive),
    .dpStat         (dpStat),
    .strobe         (strobe),
    .procGrant      (procGrant),
    .procRelinquish (procRelinquish),
    .releaseTimeout (releaseTimeout)
  );

  lbus_host_dp #(
    .ADDR_W      (ADDR_W),
    .STAGED_MASK (STAGED_MASK),
    .CFG_WORD    (CFG_WORD),
    .CFG_RESET   (CFG_RESET)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hostReq   (hostReq),
    .hostWrite (hostWrite),
    .hostByte  (hostByte),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .hostDone  (hostDone),
    .strobe    (strobe),
    .dpStat    (dpStat),
    .lbStrobe  (lbStrobe),
    .lbWrite   (lbWrite),
    .lbAddr    (lbAddr),
    .lbByteEn  (lbByteEn),
    .lbWdata   (lbWdata),
    .lbRdata   (lbRdata)
  );

endmodule

// File: rtl/lbus_arbiter_chk.sv
module lbus_arbiter_chk #(
  parameter int ADDR_W = 4,
  parameter int unsigned CFG_WORD = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              procBusAck,
  input logic              procDmaActive,
  input logic              procGrant,
  input logic              procRelinquish,
  input logic              lbStrobe,
  input logic [ADDR_W-1:0] lbAddr,
  input logic              hostDone,
  input logic              releaseTimeout
);

  localparam logic [ADDR_W-2:0] CFG_IDX = (ADDR_W-1)'(CFG_WORD);

  // R2: relinquish is held while the processor still drives the bus
  p_hold_relinquish_r2: assert property (@(posedge clk) disable iff (!rstN)
    (procRelinquish && procBusAck) |=> procRelinquish);

  // R2: a host cycle after pre-emption starts only once the bus was released
  p_strobe_after_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lbStrobe) && $past(procRelinquish)) |-> !$past(procBusAck));

  // R3: regrant follows the DMA-active sample taken after the host cycle
  p_regrant_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lbStrobe && $past(procRelinquish)) |=> ##1 (procGrant == $past(procDmaActive)));

  // R4: the configuration word never reaches the local bus
  p_cfg_masked_r4: assert property (@(posedge clk) disable iff (!rstN)
    lbStrobe |-> (lbAddr != {CFG_IDX, 1'b0} && lbAddr != {CFG_IDX, 1'b1}));

  // R9: timeout flag is sticky
  p_timeout_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    releaseTimeout |=> releaseTimeout);

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !hostDone);

endmodule

bind lbus_arbiter lbus_arbiter_chk #(.ADDR_W(ADDR_W), .CFG_WORD(CFG_WORD)) u_chk (.*);

// File: tb/sim_lbus_arbiter.sv
module sim_lbus_arbiter;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rstN, procReq, procBusAck, procDmaActive, procGrant, procRelinquish;
  logic        hostReq, hostWrite, hostByte, hostDone, lbStrobe, lbWrite, releaseTimeout;
  logic [3:0]  hostAddr, lbAddr;
  logic [15:0] hostWdata, hostRdata, lbWdata, lbRdata;
  logic [1:0]  lbByteEn;

  logic [15:0] lbMem [8];
  assign lbRdata = lbMem[lbAddr[3:1]];

  lbus_arbiter #(
    .ADDR_W(4), .STAGED_MASK(8'b0000_0111), .CFG_WORD(7),
    .CFG_RESET(16'hA5C3), .RELEASE_LIMIT(4)
  ) u0 (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int   mSt;            // 0 free,1 processor,2 releasing,3 host,4 decide
  bit   mPre, mTo, mPend, mW, mByte, mOdd, mDone;
  int   mCnt;
  int   mWord;
  logic [15:0] mData, mCfg, mRdata;
  logic [7:0]  mWst, mRst;
  bit   memWr; int memWord; logic [1:0] memEn; logic [15:0] memData;
  int   relDelay = 0, holdCnt = 0;
  bit   stubborn = 0;

  function automatic bit staged(int w); return w <= 2; endfunction
  function automatic logic [15:0] lane(logic [15:0] v);
    if (!mByte) return v;
    return mOdd ? {8'h00, v[7:0]} : {8'h00, v[15:8]};
  endfunction
  function automatic logic [1:0] expEn();
    if (!mByte || staged(mWord)) return 2'b11;
    return mOdd ? 2'b01 : 2'b10;
  endfunction
  function automatic logic [15:0] expWd();
    if (!mByte) return mData;
    if (staged(mWord)) return {mData[7:0], mWst};
    return mOdd ? {8'h00, mData[7:0]} : {mData[7:0], 8'h00};
  endfunction

  task automatic modelStep();
    bit isCfg, needBus, loc, bus; int nSt;
    memWr = 0;
    if (!rstN) begin
      mSt = 0; mPre = 0; mTo = 0; mPend = 0; mDone = 0; mCnt = 0;
      mCfg = 16'hA5C3; mRdata = 0; mWst = 0; mRst = 0;
      mW = 0; mByte = 0; mOdd = 0; mWord = 0; mData = 0;
      return;
    end
    isCfg   = (mWord == 7);
    needBus = !(isCfg || (staged(mWord) && mByte && mW && mOdd)
                      || (staged(mWord) && mByte && !mW && !mOdd));
    loc = mPend && !needBus;
    bus = (mSt == 3);
    if (loc) begin
      if (isCfg) begin
        if (!mW) mRdata = lane(mCfg);
        else if (!mByte) mCfg = mData;
        else if (mOdd) mCfg[7:0] = mData[7:0];
        else mCfg[15:8] = mData[7:0];
      end else if (mW) mWst = mData[7:0];
      else mRdata = {8'h00, mRst};
    end
    if (bus) begin
      if (mW) begin memWr = 1; memWord = mWord; memEn = expEn(); memData = expWd(); end
      else begin
        mRdata = lane(lbMem[mWord]);
        if (staged(mWord) && mByte && mOdd) mRst = lbMem[mWord][15:8];
      end
    end
    nSt = mSt;
    case (mSt)
      0: if (mPend && needBus) nSt = 3; else if (procReq) nSt = 1;
      1: if (mPend && needBus) begin nSt = 2; mPre = 1; end else if (!procReq) nSt = 0;
      2: if (!procBusAck) nSt = 3;
      3: nSt = mPre ? 4 : 0;
      default: begin nSt = procDmaActive ? 1 : 0; mPre = 0; end
    endcase
    if (mSt == 2 && procBusAck) begin
      if (mCnt == 3) mTo = 1; else mCnt++;
    end else mCnt = 0;
    mDone = loc || bus;
    if (hostReq && !mPend) begin
      mPend = 1; mW = hostWrite; mByte = hostByte; mOdd = hostAddr[0];
      mWord = int'(hostAddr[3:1]); mData = hostWdata;
    end else if (loc || bus) mPend = 0;
    mSt = nSt;
  endtask

  task automatic compareAll();
    check(procGrant == (mSt == 1), "R1", "procGrant", procGrant, mSt == 1);
    check(procRelinquish == (mSt == 2), "R2", "procRelinquish", procRelinquish, mSt == 2);
    check(lbStrobe == (mSt == 3), "R2", "lbStrobe", lbStrobe, mSt == 3);
    check(lbWrite == (mSt == 3 && mW), "R8", "lbWrite", lbWrite, mSt == 3 && mW);
    if (mSt == 3) begin
      check(lbAddr == 4'(mWord * 2), "R4", "lbAddr", lbAddr, mWord * 2);
      check(lbByteEn == expEn(), "R5", "lbByteEn", lbByteEn, expEn());
      if (mW) check(lbWdata == expWd(), "R6", "lbWdata", lbWdata, expWd());
    end
    check(hostDone == mDone, "R11", "hostDone", hostDone, mDone);
    check(hostRdata == mRdata, "R7", "hostRdata", hostRdata, mRdata);
    check(releaseTimeout == mTo, "R9", "releaseTimeout", releaseTimeout, mTo);
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    #1;
    compareAll();
    if (memWr) begin
      if (memEn[1]) lbMem[memWord][15:8] = memData[15:8];
      if (memEn[0]) lbMem[memWord][7:0]  = memData[7:0];
    end
    // processor emulation
    if (procGrant) begin procBusAck = 1; holdCnt = relDelay; end
    else if (procBusAck && !stubborn) begin
      if (holdCnt > 0) holdCnt--; else procBusAck = 0;
    end
  endtask

  task automatic hostAccess(input bit w, input bit b, input logic [3:0] a,
                            input logic [15:0] d, input bit dropProc,
                            output logic [15:0] rd);
    hostReq = 1; hostWrite = w; hostByte = b; hostAddr = a; hostWdata = d;
    tick();
    hostReq = 0;
    if (dropProc) begin procReq = 0; procDmaActive = 0; end
    for (int i = 0; i < 64 && !hostDone; i++) tick();
    rd = hostRdata;
  endtask

  task automatic waitGrant();
    for (int i = 0; i < 32 && !procGrant; i++) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    for (int i = 0; i < 8; i++) lbMem[i] = 16'h0000;
    rstN = 0; procReq = 0; procBusAck = 0; procDmaActive = 0;
    hostReq = 0; hostWrite = 0; hostByte = 0; hostAddr = 0; hostWdata = 0;
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    check(!procGrant && !procRelinquish && !lbStrobe && !hostDone && !releaseTimeout,
          "R1", "reset outputs", {procGrant, procRelinquish, lbStrobe, hostDone, releaseTimeout}, 0);

    // R4 config register
    hostAccess(0, 0, 4'hE, 0, 0, rd);
    check(rd == 16'hA5C3, "R4", "cfg reset read", rd, 16'hA5C3);
    hostAccess(1, 1, 4'hF, 16'h005A, 0, rd);
    hostAccess(1, 1, 4'hE, 16'h0011, 0, rd);
    hostAccess(0, 0, 4'hE, 0, 0, rd);
    check(rd == 16'h115A, "R4", "cfg byte writes", rd, 16'h115A);
    hostAccess(0, 1, 4'hF, 0, 0, rd);
    check(rd == 16'h005A, "R5", "cfg odd byte read", rd, 16'h005A);

    // R8 word pass-through
    hostAccess(1, 0, 4'h8, 16'hBEEF, 0, rd);
    check(lbMem[4] == 16'hBEEF, "R8", "word write", lbMem[4], 16'hBEEF);
    hostAccess(0, 0, 4'h8, 0, 0, rd);
    check(rd == 16'hBEEF, "R8", "word read", rd, 16'hBEEF);

    // R5 unstaged byte lanes
    hostAccess(1, 1, 4'hA, 16'h0012, 0, rd);
    hostAccess(1, 1, 4'hB, 16'h0034, 0, rd);
    check(lbMem[5] == 16'h1234, "R5", "byte lanes", lbMem[5], 16'h1234);
    hostAccess(0, 1, 4'hA, 0, 0, rd);
    check(rd == 16'h0012, "R5", "even byte read", rd, 16'h0012);

    // R6 staged write
    hostAccess(1, 1, 4'h1, 16'h0078, 0, rd);
    check(lbMem[0] == 16'h0000, "R6", "odd byte held", lbMem[0], 0);
    hostAccess(1, 1, 4'h0, 16'h0056, 0, rd);
    check(lbMem[0] == 16'h5678, "R6", "merged word", lbMem[0], 16'h5678);

    // R7 staged read
    hostAccess(1, 0, 4'h2, 16'h9ABC, 0, rd);
    hostAccess(0, 1, 4'h3, 0, 0, rd);
    check(rd == 16'h00BC, "R7", "odd byte read", rd, 16'h00BC);
    lbMem[1] = 16'h0000;   // held byte must not come from the bus
    hostAccess(0, 1, 4'h2, 0, 0, rd);
    check(rd == 16'h009A, "R7", "held even byte", rd, 16'h009A);

    // R1 grant, R3 regrant with DMA unfinished
    relDelay = 2; procReq = 1; procDmaActive = 1;
    tick();
    check(procGrant == 1, "R1", "grant one cycle after request", procGrant, 1);
    repeat (3) tick();
    hostAccess(0, 0, 4'h8, 0, 0, rd);
    check(rd == 16'hBEEF, "R2", "pre-empting read", rd, 16'hBEEF);
    tick();
    check(procGrant == 1, "R3", "regrant while DMA active", procGrant, 1);
    procReq = 0; procDmaActive = 0;
    repeat (3) tick();

    // R3 no regrant once DMA finished
    procReq = 1; procDmaActive = 1;
    waitGrant(); repeat (2) tick();
    hostAccess(1, 0, 4'hC, 16'h4321, 1, rd);
    repeat (3) tick();
    check(procGrant == 0, "R3", "no regrant after DMA end", procGrant, 0);
    check(lbMem[6] == 16'h4321, "R8", "pre-empting write", lbMem[6], 16'h4321);

    // R10 host first when both pending in idle
    hostReq = 1; hostWrite = 1; hostByte = 0; hostAddr = 4'h8; hostWdata = 16'h0F0F;
    tick();
    hostReq = 0; procReq = 1; procDmaActive = 1;
    for (int i = 0; i < 16 && !hostDone; i++) tick();
    check(procGrant == 0 && lbMem[4] == 16'h0F0F, "R10", "host served first", procGrant, 0);
    tick();
    check(procGrant == 1, "R10", "grant after host cycle", procGrant, 1);
    repeat (2) tick();

    // R9 release timeout
    stubborn = 1;
    hostReq = 1; hostWrite = 0; hostByte = 1; hostAddr = 4'hA;
    tick();
    hostReq = 0;
    repeat (8) tick();
    check(releaseTimeout == 1, "R9", "timeout set", releaseTimeout, 1);
    check(procRelinquish == 1 && lbStrobe == 0, "R9", "still waiting", procRelinquish, 1);
    stubborn = 0;
    for (int i = 0; i < 16 && !hostDone; i++) tick();
    check(hostRdata == 16'h0012, "R9", "access after late release", hostRdata, 16'h0012);
    repeat (3) tick();
    check(releaseTimeout == 1, "R9", "timeout sticky", releaseTimeout, 1);
    procReq = 0; procDmaActive = 0;
    repeat (4) tick();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule